// File: doc/BRIEF.md
# Real-Mode Interrupt Vector Dispatcher

This block steers execution to an interrupt handler while the core runs in real addressing mode. It accepts one request, made up of an 8-bit vector number, a class (external, exception or software), the base and limit of the vector table, and the core's current flags, code segment, instruction pointer, stack segment, stack pointer and halted state. It then runs the entry sequence on a word-wide memory port. First it checks that the four-byte table slot lies inside the limit. Next it saves the return state on the stack and fetches the handler pointer. Finally it reports the new code segment, instruction pointer, stack pointer and flags.

The core hands over a request whenever `busy` is low and waits for a one-cycle `done` or `fault` pulse. A slot outside the table ends the request with a fault and a protection error code, and the block touches no memory. The memory port carries one access at a time. The block holds a request until the memory acknowledges it.

Top module: `irq_vector_dispatch`

## Requirements
- R1: The table slot offset is the vector number times 4. The new IP is the word read at table base + offset, and the new CS is the word read at table base + offset + 2, in that order.
- R2: If offset + 3 is greater than the table limit, the block pulses `fault` for one cycle with `faultCode` = offset + 2 and makes no memory access. If offset + 3 equals the limit, the request is served normally.
- R3: On a served request the block writes exactly three stack words: the low 16 bits of the incoming flags first, then CS, then IP. Each write goes to address SS*16 + SP, where SP has first been lowered by 2 with 16-bit wraparound.
- R4: `newFlags` equals the incoming flags with bit 8 (trap), bit 9 (interrupt enable), bit 16 (resume) and bit 18 (alignment check) cleared. Every other bit passes through unchanged.
- R5: For an external request (class 0) that arrives while `halted` is high, the pushed IP is the incoming IP + 1 (16-bit wrap), and `haltRelease` is high during `done`. For exception (class 1) and software (class 2) requests, the pushed IP is unmodified and `haltRelease` is low.
- R6: `done` and `fault` are single-cycle pulses and never occur together. `newCs`, `newIp`, `newSp` and `newFlags` are valid while `done` is high. `busy` rises in the cycle after a request is accepted and drops after the pulse.
- R7: `reqValid` is ignored while `busy` is high. Such a request changes neither the results nor the memory traffic, and it produces no extra pulse.
- R8: While `memReq` is high and `memAck` is low, `memReq`, `memWe`, `memAddr` and `memWdata` stay stable in the next cycle.
- R9: `newSp` equals the incoming SP − 6 modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, taken when not busy |
| reqVector | input | 8 | Vector number |
| reqClass | input | 2 | 0 external, 1 exception, 2 software |
| halted | input | 1 | Core is halted |
| tblBase | input | 20 | Vector table base address |
| tblLimit | input | 16 | Vector table limit (last valid byte offset) |
| flagsIn | input | 32 | Current flags |
| csIn | input | 16 | Current code segment |
| ipIn | input | 16 | Current instruction pointer |
| ssIn | input | 16 | Current stack segment |
| spIn | input | 16 | Current stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Dispatch complete, results valid |
| fault | output | 1 | Table limit violation |
| faultCode | output | 16 | Protection error code (offset + 2) |
| haltRelease | output | 1 | Halt state cleared, valid with done |
| newFlags | output | 32 | Flags after entry |
| newCs | output | 16 | Handler code segment |
| newIp | output | 16 | Handler instruction pointer |
| newSp | output | 16 | Stack pointer after the pushes |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | Access is a write |
| memAddr | output | 20 | Access address |
| memWdata | output | 16 | Write word |
| memRdata | input | 16 | Read word, valid with memAck |
| memAck | input | 1 | Access complete |

## Verification
The design keeps the stack pointer in a register. If that register moves at the wrong moment, every stack write from that point lands at the wrong address, so the first logged push already shows the error, well before `done`. A fault decision taken on the wrong offset shows up at once: the block either issues memory traffic where none should appear, or raises a pulse of the wrong kind within two cycles of acceptance. A mistake in the halt or flag handling appears in the third pushed word and in `newFlags` at the `done` pulse. Each of these cases is driven so that the mismatch shows at a port on the first affected request.

// File: rtl/irq_dispatch_pkg.sv
package irq_dispatch_pkg;
  typedef enum logic [1:0] {CLS_EXT = 2'd0, CLS_EXC = 2'd1, CLS_SOFT = 2'd2} irqClass_e;

  typedef enum logic [2:0] {
    ACC_NONE, ACC_FLAGS, ACC_CS, ACC_IP, ACC_RDIP, ACC_RDCS
  } accSel_e;

  typedef struct packed {
    logic    load;      // capture request inputs
    logic    pushStep;  // a push was acknowledged: commit SP
    logic    grabIp;    // capture handler offset
    logic    grabCs;    // capture handler segment
    accSel_e sel;       // what the memory port carries
  } dpCtrl_t;
endpackage

// File: rtl/irq_dispatch_ctrl.sv
module irq_dispatch_ctrl
  import irq_dispatch_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    limFault,
  input  logic    memAck,
  output dpCtrl_t ctl,
  output logic    memReq,
  output logic    memWe,
  output logic    busy,
  output logic    done,
  output logic    fault
);
  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_PUSH_FL, S_PUSH_CS, S_PUSH_IP, S_READ_IP, S_READ_CS, S_DONE, S_FAULT
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState    = state;
    ctl          = '0;
    ctl.sel      = ACC_NONE;
    memReq       = 1'b0;
    memWe        = 1'b0;
    done         = 1'b0;
    fault        = 1'b0;
    unique case (state)
      S_IDLE: if (reqValid) begin
        ctl.load  = 1'b1;
        nextState = S_CHECK;
      end
      S_CHECK: nextState = limFault ? S_FAULT : S_PUSH_FL;
      S_PUSH_FL: begin
        ctl.sel = ACC_FLAGS; memReq = 1'b1; memWe = 1'b1;
        if (memAck) begin ctl.pushStep = 1'b1; nextState = S_PUSH_CS; end
      end
      S_PUSH_CS: begin
        ctl.sel = ACC_CS; memReq = 1'b1; memWe = 1'b1;
        if (memAck) begin ctl.pushStep = 1'b1; nextState = S_PUSH_IP; end
      end
      S_PUSH_IP: begin
        ctl.sel = ACC_IP; memReq = 1'b1; memWe = 1'b1;
        if (memAck) begin ctl.pushStep = 1'b1; nextState = S_READ_IP; end
      end
      S_READ_IP: begin
        ctl.sel = ACC_RDIP; memReq = 1'b1;
        if (memAck) begin ctl.grabIp = 1'b1; nextState = S_READ_CS; end
      end
      S_READ_CS: begin
        ctl.sel = ACC_RDCS; memReq = 1'b1;
        if (memAck) begin ctl.grabCs = 1'b1; nextState = S_DONE; end
      end
      S_DONE: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      S_FAULT: begin
        fault     = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign busy = (state != S_IDLE);
endmodule

// File: rtl/irq_dispatch_dp.sv
module irq_dispatch_dp
  import irq_dispatch_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16,
  parameter int VEC_W  = 8,
  parameter int LIM_W  = 16,
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctl,
  input  logic [VEC_W-1:0]  reqVector,
  input  logic [1:0]        reqClass,
  input  logic              halted,
  input  logic [ADDR_W-1:0] tblBase,
  input  logic [LIM_W-1:0]  tblLimit,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [WORD_W-1:0] csIn,
  input  logic [WORD_W-1:0] ipIn,
  input  logic [WORD_W-1:0] ssIn,
  input  logic [WORD_W-1:0] spIn,
  input  logic [WORD_W-1:0] memRdata,
  output logic              limFault,
  output logic [WORD_W-1:0] faultCode,
  output logic              haltRelease,
  output logic [FLAG_W-1:0] newFlags,
  output logic [WORD_W-1:0] newCs,
  output logic [WORD_W-1:0] newIp,
  output logic [WORD_W-1:0] newSp,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata
);
  localparam int OFF_W   = VEC_W + 2;
  localparam int CMP_W   = ((OFF_W > LIM_W) ? OFF_W : LIM_W) + 1;
  localparam int SEG_SH  = 4;
  localparam int TF_BIT  = 8;
  localparam int IF_BIT  = 9;
  localparam int RF_BIT  = 16;
  localparam int AC_BIT  = 18;
  localparam logic [FLAG_W-1:0] CLR_MASK =
      (FLAG_W'(1) << TF_BIT) | (FLAG_W'(1) << IF_BIT) |
      (FLAG_W'(1) << RF_BIT) | (FLAG_W'(1) << AC_BIT);

  logic [OFF_W-1:0]  offReg;
  logic [LIM_W-1:0]  limReg;
  logic [ADDR_W-1:0] baseReg;
  logic [FLAG_W-1:0] flagsReg;
  logic [WORD_W-1:0] csReg, ipReg, ssReg, spReg, newIpReg, newCsReg;
  logic              wakeReg;
  logic [WORD_W-1:0] spNext;
  logic [ADDR_W-1:0] stackAddr, slotAddr;
  logic              wake;

  assign wake   = (reqClass == CLS_EXT) && halted;
  assign spNext = spReg - WORD_W'(2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      offReg <= '0; limReg <= '0; baseReg <= '0; flagsReg <= '0;
      csReg <= '0; ipReg <= '0; ssReg <= '0; spReg <= '0;
      newIpReg <= '0; newCsReg <= '0; wakeReg <= 1'b0;
    end else begin
      if (ctl.load) begin
        offReg   <= {reqVector, 2'b00};
        limReg   <= tblLimit;
        baseReg  <= tblBase;
        flagsReg <= flagsIn;
        csReg    <= csIn;
        ipReg    <= wake ? ipIn + WORD_W'(1) : ipIn;
        ssReg    <= ssIn;
        spReg    <= spIn;
        wakeReg  <= wake;
      end
      if (ctl.pushStep) spReg    <= spNext;
      if (ctl.grabIp)   newIpReg <= memRdata;
      if (ctl.grabCs)   newCsReg <= memRdata;
    end
  end

  assign limFault  = (CMP_W'(offReg) + CMP_W'(3)) > CMP_W'(limReg);
  assign faultCode = WORD_W'(offReg) + WORD_W'(2);

  assign stackAddr = ADDR_W'({ssReg, {SEG_SH{1'b0}}}) + ADDR_W'(spNext);
  assign slotAddr  = baseReg + ADDR_W'(offReg);

  always_comb begin
    memAddr  = '0;
    memWdata = '0;
    unique case (ctl.sel)
      ACC_FLAGS: begin memAddr = stackAddr; memWdata = flagsReg[WORD_W-1:0]; end
      ACC_CS:    begin memAddr = stackAddr; memWdata = csReg; end
      ACC_IP:    begin memAddr = stackAddr; memWdata = ipReg; end
      ACC_RDIP:  memAddr = slotAddr;
      ACC_RDCS:  memAddr = slotAddr + ADDR_W'(2);
      default:   ;
    endcase
  end

  assign newFlags    = flagsReg & ~CLR_MASK;
  assign newCs       = newCsReg;
  assign newIp       = newIpReg;
  assign newSp       = spReg;
  assign haltRelease = wakeReg;
endmodule

// File: rtl/irq_vector_dispatch.sv
module irq_vector_dispatch
  import irq_dispatch_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16,
  parameter int VEC_W  = 8,
  parameter int LIM_W  = 16,
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [VEC_W-1:0]  reqVector,
  input  logic [1:0]        reqClass,
  input  logic              halted,
  input  logic [ADDR_W-1:0] tblBase,
  input  logic [LIM_W-1:0]  tblLimit,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [WORD_W-1:0] csIn,
  input  logic [WORD_W-1:0] ipIn,
  input  logic [WORD_W-1:0] ssIn,
  input  logic [WORD_W-1:0] spIn,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [WORD_W-1:0] faultCode,
  output logic              haltRelease,
  output logic [FLAG_W-1:0] newFlags,
  output logic [WORD_W-1:0] newCs,
  output logic [WORD_W-1:0] newIp,
  output logic [WORD_W-1:0] newSp,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWdata,
  input  logic [WORD_W-1:0] memRdata,
  input  logic              memAck
);
  dpCtrl_t ctl;
  logic    limFault;

  irq_dispatch_ctrl ctrlInst (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .limFault(limFault),
    .memAck(memAck), .ctl(ctl), .memReq(memReq), .memWe(memWe),
    .busy(busy), .done(done), .fault(fault)
  );

  irq_dispatch_dp #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .VEC_W(VEC_W), .LIM_W(LIM_W), .FLAG_W(FLAG_W)
  ) dpInst (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqVector(reqVector), .reqClass(reqClass),
    .halted(halted), .tblBase(tblBase), .tblLimit(tblLimit), .flagsIn(flagsIn),
    .csIn(csIn), .ipIn(ipIn), .ssIn(ssIn), .spIn(spIn), .memRdata(memRdata),
    .limFault(limFault), .faultCode(faultCode), .haltRelease(haltRelease),
    .newFlags(newFlags), .newCs(newCs), .newIp(newIp), .newSp(newSp),
    .memAddr(memAddr), .memWdata(memWdata)
  );
endmodule

// File: rtl/irq_vector_dispatch_chk.sv
module irq_vector_dispatch_chk #(
  parameter int ADDR_W = 20,
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [WORD_W-1:0] faultCode,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [WORD_W-1:0] memWdata,
  input logic              memAck
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R6
  fault_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) fault |=> !fault);
  // R6
  done_fault_excl_chk: assert property (@(posedge clk) disable iff (!rstN) !(done && fault));
  // R6
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN) (!busy && reqValid) |=> busy);
  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && !fault) |=> busy);
  // R2
  fault_code_chk: assert property (@(posedge clk) disable iff (!rstN) fault |-> (faultCode[1:0] == 2'b10));
  // R2
  fault_no_mem_chk: assert property (@(posedge clk) disable iff (!rstN) fault |-> !memReq);
  // R8
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata)));
endmodule

bind irq_vector_dispatch irq_vector_dispatch_chk #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) chkInst (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busy(busy), .done(done), .fault(fault),
  .faultCode(faultCode), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .memAck(memAck)
);

// File: tb/irq_vector_dispatch_test.sv
`timescale 1ns/1ps
module irq_vector_dispatch_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqVector = '0;
  logic [1:0]  reqClass = '0;
  logic        halted = 1'b0;
  logic [19:0] tblBase = '0;
  logic [15:0] tblLimit = '0;
  logic [31:0] flagsIn = '0;
  logic [15:0] csIn = '0, ipIn = '0, ssIn = '0, spIn = '0;
  logic        busy, done, fault, haltRelease, memReq, memWe;
  logic [15:0] faultCode, newCs, newIp, newSp, memWdata;
  logic [31:0] newFlags;
  logic [19:0] memAddr;
  logic [15:0] memRdata = '0;
  logic        memAck = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [19:0] wrAddr [0:7];
  logic [15:0] wrData [0:7];
  int          wrCount = 0;
  int          rdCount = 0;

  always #2.5 clk = ~clk;

  irq_vector_dispatch uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqVector(reqVector), .reqClass(reqClass),
    .halted(halted), .tblBase(tblBase), .tblLimit(tblLimit), .flagsIn(flagsIn),
    .csIn(csIn), .ipIn(ipIn), .ssIn(ssIn), .spIn(spIn), .busy(busy), .done(done),
    .fault(fault), .faultCode(faultCode), .haltRelease(haltRelease), .newFlags(newFlags),
    .newCs(newCs), .newIp(newIp), .newSp(newSp), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memAck(memAck)
  );

  function automatic logic [15:0] tableWord(logic [19:0] a);
    return a[15:0] ^ 16'h3C5A ^ {12'h000, a[19:16]};
  endfunction

  // memory model: acknowledges each access one cycle after it appears
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rstN) memAck <= 1'b0;
    else if (memReq && !memAck) begin
      memAck <= 1'b1;
      if (memWe) begin
        if (wrCount < 8) begin wrAddr[wrCount] <= memAddr; wrData[wrCount] <= memWdata; end
        wrCount <= wrCount + 1;
      end else begin
        memRdata <= tableWord(memAddr);
        rdCount  <= rdCount + 1;
      end
    end else memAck <= 1'b0;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic finish();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  // One dispatch; checks every result against the requirement-derived model.
  task automatic runOne(input logic [7:0] vec, input logic [1:0] cls, input bit hlt,
                        input logic [15:0] lim, input logic [19:0] base, input logic [31:0] flg,
                        input logic [15:0] cs, input logic [15:0] ip, input logic [15:0] ss,
                        input logic [15:0] sp, input bit interfere);
    logic [16:0] off;
    bit          expFault;
    logic [15:0] expIp, pushIp, s;
    int          wait_n;
    off      = {7'd0, vec, 2'b00};
    expFault = (off + 17'd3) > {1'b0, lim};
    pushIp   = (cls == 2'd0 && hlt) ? ip + 16'd1 : ip;
    @(negedge clk);
    wrCount = 0; rdCount = 0;
    reqVector = vec; reqClass = cls; halted = hlt; tblLimit = lim; tblBase = base;
    flagsIn = flg; csIn = cs; ipIn = ip; ssIn = ss; spIn = sp; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (interfere) begin
      @(negedge clk);
      // R7: request while busy, with different inputs
      reqValid = 1'b1; reqVector = vec + 8'd1; spIn = sp + 16'h0100; ipIn = ip ^ 16'hFFFF;
      @(negedge clk);
      reqValid = 1'b0;
    end
    wait_n = 0;
    while (!(done || fault) && wait_n < 100) begin @(negedge clk); wait_n++; end
    check(fault == expFault && done == !expFault, "R2", "fault/done outcome",
          {fault, done}, {expFault, !expFault});
    if (expFault) begin
      check(faultCode == off[15:0] + 16'd2, "R2", "fault code", faultCode, off[15:0] + 16'd2);
      check(wrCount == 0 && rdCount == 0, "R2", "no memory access on fault", wrCount + rdCount, 0);
    end else begin
      check(wrCount == 3, "R3", "push count", wrCount, 3);
      s = sp;
      for (int k = 0; k < 3; k++) begin
        logic [15:0] ed;
        s  = s - 16'd2;
        ed = (k == 0) ? flg[15:0] : (k == 1) ? cs : pushIp;
        check(wrAddr[k] == ({ss, 4'h0} + {4'h0, s}), "R3", "push address", wrAddr[k], {ss, 4'h0} + {4'h0, s});
        check(wrData[k] == ed, (k == 2) ? "R5" : "R3", "push word", wrData[k], ed);
      end
      check(rdCount == 2, "R1", "table read count", rdCount, 2);
      expIp = tableWord(base + off[9:0]);
      check(newIp == expIp, "R1", "new IP", newIp, expIp);
      check(newCs == tableWord(base + off[9:0] + 20'd2), "R1", "new CS", newCs, tableWord(base + off[9:0] + 20'd2));
      check(newFlags == (flg & ~32'h0005_0300), "R4", "new flags", newFlags, flg & ~32'h0005_0300);
      check(newSp == sp - 16'd6, "R9", "new SP", newSp, sp - 16'd6);
      check(haltRelease == (cls == 2'd0 && hlt), "R5", "halt release", haltRelease, (cls == 2'd0 && hlt));
    end
    @(negedge clk);
    check(!done && !fault && !busy, "R6", "single-cycle pulse then idle", {busy, done, fault}, 0);
    if (interfere) begin
      repeat (4) @(negedge clk);
      check(!busy && !done && !fault && wrCount == 3, "R7", "ignored request left no trace",
            {busy, done, fault}, 0);
    end
  endtask

  task automatic testReset();
    check(!busy && !done && !fault && !memReq, "R6", "reset state", {busy, done, fault, memReq}, 0);
  endtask

  task automatic testSweepFull();  // R1 R3 R4 R5 R9 over every vector
    for (int v = 0; v < 256; v++)
      runOne(v[7:0], 2'(v % 3), v[0], 16'h03FF, 20'h01230, 32'hFFFF_FFFF ^ (v << 4),
             16'hC000 + 16'(v), 16'h1000 + 16'(v * 7), 16'h2000, 16'h0800, 1'b0);
  endtask

  task automatic testSweepHalfLimit();  // R2: vectors >= 128 fault
    for (int v = 0; v < 256; v++)
      runOne(v[7:0], 2'd1, 1'b0, 16'h01FF, 20'h00000, 32'h0000_0302, 16'h1111,
             16'h2222, 16'h3000, 16'h0100, 1'b0);
  endtask

  task automatic testBoundary();  // R2 edge: off+3 == limit serves, limit one lower faults
    runOne(8'd16, 2'd2, 1'b0, 16'd67, 20'h10000, 32'h0004_0200, 16'h0101, 16'h0202, 16'h0303, 16'h0404, 1'b0);
    runOne(8'd16, 2'd2, 1'b0, 16'd66, 20'h10000, 32'h0004_0200, 16'h0101, 16'h0202, 16'h0303, 16'h0404, 1'b0);
    runOne(8'd0,  2'd0, 1'b0, 16'd2,  20'h10000, 32'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b0);
  endtask

  task automatic testStackWrap();  // R3 R9: SP wraps through zero
    runOne(8'h21, 2'd2, 1'b0, 16'hFFFF, 20'h00400, 32'h0001_0100, 16'hABCD, 16'h1234, 16'hF000, 16'h0002, 1'b0);
    runOne(8'h08, 2'd0, 1'b0, 16'hFFFF, 20'h00400, 32'h0000_0200, 16'hABCD, 16'h1234, 16'hFFFF, 16'h0000, 1'b0);
  endtask

  task automatic testHalt();  // R5: only external requests adjust IP
    runOne(8'h09, 2'd0, 1'b1, 16'h03FF, 20'h00000, 32'h0000_0200, 16'h0F00, 16'hFFFF, 16'h0100, 16'h2000, 1'b0);
    runOne(8'h09, 2'd1, 1'b1, 16'h03FF, 20'h00000, 32'h0000_0200, 16'h0F00, 16'h7FFF, 16'h0100, 16'h2000, 1'b0);
    runOne(8'h09, 2'd2, 1'b1, 16'h03FF, 20'h00000, 32'h0000_0200, 16'h0F00, 16'h7FFF, 16'h0100, 16'h2000, 1'b0);
    runOne(8'h09, 2'd0, 1'b0, 16'h03FF, 20'h00000, 32'h0000_0200, 16'h0F00, 16'h7FFF, 16'h0100, 16'h2000, 1'b0);
  endtask

  task automatic testBusyIgnore();  // R7
    runOne(8'h05, 2'd1, 1'b0, 16'h03FF, 20'h08000, 32'h0000_0346, 16'h5555, 16'h6666, 16'h0700, 16'h0FFE, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBoundary();
    testStackWrap();
    testHalt();
    testBusyIgnore();
    testSweepFull();
    testSweepHalfLimit();
    finish();
  end
endmodule